// File: doc/BRIEF.md
# Indexed Register and Video-Memory Host Port

This block is the host-facing front of a video display controller. A host on an 8-bit bus sees two ports. The index port selects one of twenty internal 16-bit registers. The data port reads and writes the selected register one byte at a time. A low-byte write is held in a staging byte. The high-byte write then completes the 16-bit word, and only that high-byte access commits the word.

The block owns two video-memory pointers: a write pointer and a read pointer. It also owns a read latch. A committed write to the data register stores the word in video memory at the write pointer. A high-byte read of the data register returns latched data and refetches from the next read address. After each of these commits, the affected pointer moves by a step that the control register selects. Writes to registers that this block does not own go out on a one-cycle forwarding strobe for the rest of the controller to decode. Writes to the reserved slots and to indices past the last register are dropped.

Top module: `vid_hostport`

## Requirements
- R1: A write to the index port (`host_port`=0) with `host_hi`=0 loads `host_wdata[4:0]` as the register index, and a high-byte write there has no effect. A read of the index port returns `status_in[7:0]` when `host_hi`=0 and `status_in[15:8]` when `host_hi`=1.
- R2: A low-byte write to the data port (`host_port`=1) only loads the staging byte. A high-byte write forms the word {`host_wdata`, staging byte}. With index 0 that word becomes the write pointer, and with index 1 it becomes the read pointer.
- R3: A high-byte data-port write with index 2 pulses `vram_we` for exactly one cycle, in the cycle after the access. `vram_addr` carries the write pointer as it stood before the access, and `vram_wdata` carries the formed word. A low-byte write never starts a video-memory access.
- R4: After each index-2 commit, the write pointer advances by the current step.
- R5: Loading index 1 pulses `vram_re` in the next cycle, addressed at the new read pointer. `vram_rdata` is valid in the cycle after `vram_re`, and the read latch captures it at the end of that cycle. A data-port read with index 2 returns latch bits 7:0 (low byte) or 15:8 (high byte). A data-port read with any other index returns 0.
- R6: A high-byte data-port read with index 2 advances the read pointer by the step and refetches the latch from the new address. A low-byte read changes nothing.
- R7: Bits 12:11 of the word written to index 5 select the step: 00→1, 01→32, 10→64, 11→128.
- R8: Committed writes to indices 3 and 4, or to indices 20 to 31, cause no forwarding strobe, no video-memory access and no pointer change.
- R9: A committed write to indices 5 to 19 pulses `reg_wr` for one cycle, in the cycle after the access, with `reg_idx` and `reg_wdata` holding the index and the word.
- R10: Pointer arithmetic wraps modulo 65536.
- R11: After reset the index is 0, both pointers are 0, the latch is 0, the step is 1, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_port | input | 1 | 0 = index/status port, 1 = data port |
| host_hi | input | 1 | Byte select, 1 = high byte |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid while `host_rd` is high |
| status_in | input | 16 | Status word supplied by the rest of the controller |
| vram_addr | output | 16 | Video-memory address |
| vram_we | output | 1 | Video-memory write strobe |
| vram_wdata | output | 16 | Video-memory write word |
| vram_re | output | 1 | Video-memory read strobe |
| vram_rdata | input | 16 | Video-memory read word, valid the cycle after `vram_re` |
| reg_wr | output | 1 | Forwarded register write strobe |
| reg_idx | output | 5 | Forwarded register index |
| reg_wdata | output | 16 | Forwarded register word |

## Verification
The bench builds the block with the table step decoder, which is the default, and with twenty registers. Drawn indices up to 23 therefore land in the forwarded, reserved and out-of-range ranges, and not only in the pointer and data slots. Random control-register words cycle through all four step sizes between pointer commits. Directed cases preload the pointers near 0xFFFF so that a step of 128 carries both pointers across the wrap boundary.

// File: rtl/vhp_pkg.sv
package vhp_pkg;
   localparam int WORD_W = 16;
   localparam int BYTE_W = 8;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [1:0]        step_sel_t;

   // one outstanding video-memory request
   typedef struct packed {
      logic  we;
      logic  re;
      word_t addr;
      word_t data;
   } vram_req_t;
endpackage

// File: rtl/vhp_index_reg.sv
module vhp_index_reg #(
   parameter int IDX_W      = 5,
   parameter int NUM_REGS   = 20,
   parameter int RSVD_FIRST = 3,
   parameter int RSVD_LAST  = 4,
   parameter int CTRL_IDX   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] din,
   output logic [IDX_W-1:0] idx,
   output logic             sel_wptr,
   output logic             sel_rptr,
   output logic             sel_data,
   output logic             sel_ctrl,
   output logic             sel_fwd
);
   localparam int WPTR_IDX = 0;
   localparam int RPTR_IDX = 1;
   localparam int DATA_IDX = 2;

   logic in_range, reserved;

   always_ff @(posedge clk) begin
      if (!rst_n)    idx <= '0;
      else if (load) idx <= din;
   end

   always_comb begin
      in_range = int'(idx) < NUM_REGS;
      reserved = (int'(idx) >= RSVD_FIRST) && (int'(idx) <= RSVD_LAST);
      sel_wptr = int'(idx) == WPTR_IDX;
      sel_rptr = int'(idx) == RPTR_IDX;
      sel_data = int'(idx) == DATA_IDX;
      sel_ctrl = int'(idx) == CTRL_IDX;
      sel_fwd  = in_range && !reserved && (int'(idx) > DATA_IDX);
   end
endmodule

// File: rtl/vhp_byte_stage.sv
module vhp_byte_stage
   import vhp_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  lo_load,
   input  byte_t lo_in,
   input  byte_t hi_in,
   output word_t word
);
   byte_t lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       lo_q <= '0;
      else if (lo_load) lo_q <= lo_in;
   end

   assign word = {hi_in, lo_q};
endmodule

// File: rtl/vhp_ptr_unit.sv
module vhp_ptr_unit
   import vhp_pkg::*;
#(
   parameter int PTR_W     = 16,
   parameter int STEP_IMPL = 0   // 0: table decode, 1: shift decode
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PTR_W-1:0] load_val,
   input  logic             advance,
   input  step_sel_t        step_sel,
   output logic [PTR_W-1:0] ptr,
   output logic [PTR_W-1:0] ptr_nxt,
   output logic [PTR_W-1:0] step
);
   generate
      if (STEP_IMPL == 0) begin : g_table
         always_comb begin
            case (step_sel)
               2'd0:    step = PTR_W'(1);
               2'd1:    step = PTR_W'(32);
               2'd2:    step = PTR_W'(64);
               default: step = PTR_W'(128);
            endcase
         end
      end else begin : g_shift
         always_comb begin
            if (step_sel == 2'd0) step = PTR_W'(1);
            else                  step = PTR_W'(1) << (int'(step_sel) + 4);
         end
      end
   endgenerate

   always_comb begin
      ptr_nxt = ptr;
      if (load)         ptr_nxt = load_val;
      else if (advance) ptr_nxt = ptr + step;   // wraps at 2**PTR_W
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr <= '0;
      else        ptr <= ptr_nxt;
   end
endmodule

// File: rtl/vid_hostport.sv
module vid_hostport
   import vhp_pkg::*;
#(
   parameter int IDX_W      = 5,
   parameter int NUM_REGS   = 20,
   parameter int RSVD_FIRST = 3,
   parameter int RSVD_LAST  = 4,
   parameter int CTRL_IDX   = 5,
   parameter int STEP_LSB   = 11,
   parameter int STEP_IMPL  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_port,
   input  logic             host_hi,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata,
   input  logic [15:0]      status_in,
   output logic [15:0]      vram_addr,
   output logic             vram_we,
   output logic [15:0]      vram_wdata,
   output logic             vram_re,
   input  logic [15:0]      vram_rdata,
   output logic             reg_wr,
   output logic [IDX_W-1:0] reg_idx,
   output logic [15:0]      reg_wdata
);
   localparam int PTR_W = WORD_W;

   generate
      if (NUM_REGS > (1 << IDX_W)) begin : g_chk_idx
         $error("NUM_REGS does not fit in IDX_W bits");
      end
      if (RSVD_FIRST <= 2 || RSVD_LAST < RSVD_FIRST || RSVD_LAST >= NUM_REGS) begin : g_chk_rsvd
         $error("reserved range must lie between the data slot and NUM_REGS");
      end
      if (CTRL_IDX <= RSVD_LAST || CTRL_IDX >= NUM_REGS) begin : g_chk_ctrl
         $error("control index must be a forwarded register");
      end
      if (STEP_LSB < 0 || STEP_LSB > WORD_W - 2) begin : g_chk_lsb
         $error("step field outside the word");
      end
      if (STEP_IMPL != 0 && STEP_IMPL != 1) begin : g_chk_impl
         $error("STEP_IMPL must be 0 or 1");
      end
   endgenerate

   // host access decode
   logic idx_load, lo_wr, hi_wr, hi_rd;
   assign idx_load = host_wr && !host_port && !host_hi;
   assign lo_wr    = host_wr &&  host_port && !host_hi;
   assign hi_wr    = host_wr &&  host_port &&  host_hi;
   assign hi_rd    = host_rd &&  host_port &&  host_hi;

   logic [IDX_W-1:0] idx_q;
   logic sel_wptr, sel_rptr, sel_data, sel_ctrl, sel_fwd;

   vhp_index_reg #(
      .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .RSVD_FIRST(RSVD_FIRST),
      .RSVD_LAST(RSVD_LAST), .CTRL_IDX(CTRL_IDX)
   ) u_index (
      .clk(clk), .rst_n(rst_n), .load(idx_load), .din(host_wdata[IDX_W-1:0]),
      .idx(idx_q), .sel_wptr(sel_wptr), .sel_rptr(sel_rptr),
      .sel_data(sel_data), .sel_ctrl(sel_ctrl), .sel_fwd(sel_fwd)
   );

   word_t word;
   vhp_byte_stage u_stage (
      .clk(clk), .rst_n(rst_n), .lo_load(lo_wr), .lo_in(host_wdata),
      .hi_in(host_wdata), .word(word)
   );

   // step selection held locally from the control register
   step_sel_t step_sel_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                 step_sel_q <= 2'd0;
      else if (hi_wr && sel_ctrl) step_sel_q <= word[STEP_LSB +: 2];
   end

   logic [PTR_W-1:0] wptr_q, wptr_nxt, rptr_q, rptr_nxt, step_val, step_r;
   logic wr_commit, rd_load, rd_adv;
   assign wr_commit = hi_wr && sel_data;
   assign rd_load   = hi_wr && sel_rptr;
   assign rd_adv    = hi_rd && sel_data;

   vhp_ptr_unit #(.PTR_W(PTR_W), .STEP_IMPL(STEP_IMPL)) u_wptr (
      .clk(clk), .rst_n(rst_n), .load(hi_wr && sel_wptr), .load_val(word),
      .advance(wr_commit), .step_sel(step_sel_q),
      .ptr(wptr_q), .ptr_nxt(wptr_nxt), .step(step_val)
   );

   vhp_ptr_unit #(.PTR_W(PTR_W), .STEP_IMPL(STEP_IMPL)) u_rptr (
      .clk(clk), .rst_n(rst_n), .load(rd_load), .load_val(word),
      .advance(rd_adv), .step_sel(step_sel_q),
      .ptr(rptr_q), .ptr_nxt(rptr_nxt), .step(step_r)
   );

   // video-memory request register: at most one host access per cycle,
   // so a write and a fetch never compete
   vram_req_t req_q;
   logic      fetch_d;
   word_t     latch_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q   <= '0;
         fetch_d <= 1'b0;
         latch_q <= '0;
      end else begin
         req_q.we   <= wr_commit;
         req_q.re   <= rd_load || rd_adv;
         req_q.addr <= wr_commit ? wptr_q : rptr_nxt;
         req_q.data <= word;
         fetch_d    <= req_q.re;
         if (fetch_d) latch_q <= vram_rdata;
      end
   end

   assign vram_we    = req_q.we;
   assign vram_re    = req_q.re;
   assign vram_addr  = req_q.addr;
   assign vram_wdata = req_q.data;

   // forwarding of registers owned elsewhere
   logic             fwd_q;
   logic [IDX_W-1:0] fwd_idx_q;
   word_t            fwd_data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_q      <= 1'b0;
         fwd_idx_q  <= '0;
         fwd_data_q <= '0;
      end else begin
         fwd_q <= hi_wr && sel_fwd;
         if (hi_wr && sel_fwd) begin
            fwd_idx_q  <= idx_q;
            fwd_data_q <= word;
         end
      end
   end

   assign reg_wr    = fwd_q;
   assign reg_idx   = fwd_idx_q;
   assign reg_wdata = fwd_data_q;

   // host read mux
   always_comb begin
      host_rdata = '0;
      if (host_rd) begin
         if (!host_port)    host_rdata = host_hi ? status_in[15:8] : status_in[7:0];
         else if (sel_data) host_rdata = host_hi ? latch_q[15:8]   : latch_q[7:0];
      end
   end

   logic unused_step_r;
   assign unused_step_r = ^step_r;
endmodule

// File: rtl/vhp_checker.sv
module vhp_checker #(
   parameter int IDX_W      = 5,
   parameter int NUM_REGS   = 20,
   parameter int RSVD_FIRST = 3,
   parameter int RSVD_LAST  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_port,
   input logic             host_hi,
   input logic             host_wr,
   input logic             host_rd,
   input logic             vram_we,
   input logic             vram_re,
   input logic             reg_wr,
   input logic [IDX_W-1:0] reg_idx,
   input logic [15:0]      wptr,
   input logic [15:0]      step
);
   assert_vram_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(vram_we && vram_re));

   assert_write_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vram_we |-> $past(host_wr && host_port && host_hi));

   assert_fetch_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vram_re |-> $past(host_port && host_hi && (host_wr || host_rd)));

   assert_wptr_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wptr) |-> $past(host_wr && host_port && host_hi));

   assert_fwd_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> (int'(reg_idx) > RSVD_LAST && int'(reg_idx) < NUM_REGS));

   assert_fwd_not_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> !(int'(reg_idx) >= RSVD_FIRST && int'(reg_idx) <= RSVD_LAST));

   assert_fwd_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> $past(host_wr && host_port && host_hi));

   assert_step_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(step) == 1 && step <= 16'd128);
endmodule

bind vid_hostport vhp_checker #(
   .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .RSVD_FIRST(RSVD_FIRST), .RSVD_LAST(RSVD_LAST)
) u_vhp_checker (
   .clk(clk), .rst_n(rst_n), .host_port(host_port), .host_hi(host_hi),
   .host_wr(host_wr), .host_rd(host_rd), .vram_we(vram_we), .vram_re(vram_re),
   .reg_wr(reg_wr), .reg_idx(reg_idx), .wptr(wptr_q), .step(step_val)
);

// File: tb/test_vid_hostport.sv
module test_vid_hostport;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_port = 1'b0, host_hi = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [15:0] status_in = 16'h0000;
   logic [15:0] vram_addr, vram_wdata;
   logic        vram_we, vram_re;
   logic [15:0] vram_rdata = '0;
   logic        reg_wr;
   logic [4:0]  reg_idx;
   logic [15:0] reg_wdata;

   always #4 clk = ~clk;   // 125 MHz

   vid_hostport i_vid_hostport (
      .clk(clk), .rst_n(rst_n), .host_port(host_port), .host_hi(host_hi),
      .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .status_in(status_in), .vram_addr(vram_addr),
      .vram_we(vram_we), .vram_wdata(vram_wdata), .vram_re(vram_re),
      .vram_rdata(vram_rdata), .reg_wr(reg_wr), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata)
   );

   // behavioural video memory, one-cycle read latency
   logic [15:0] mem [int];
   function automatic logic [15:0] peek(input logic [15:0] a);
      if (mem.exists(int'(a))) return mem[int'(a)];
      return a ^ 16'h5A3C;
   endfunction

   always @(posedge clk) begin
      if (vram_we) mem[int'(vram_addr)] = vram_wdata;
      if (vram_re) vram_rdata <= peek(vram_addr);
   end

   int n_checks = 0, n_fail = 0, cycles = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference model state
   logic [15:0] m_wptr = 0, m_rptr = 0, m_latch = 0;
   logic [7:0]  m_lo = 0;
   logic [4:0]  m_idx = 0;
   logic [1:0]  m_sel = 0;

   function automatic logic [15:0] step_of(input logic [1:0] s);
      case (s)
         2'd0: return 16'd1;
         2'd1: return 16'd32;
         2'd2: return 16'd64;
         default: return 16'd128;
      endcase
   endfunction

   // observed strobes, captured one cycle after an access
   logic o_we, o_re, o_fwd;
   logic [15:0] o_addr, o_wdata, o_fdata;
   logic [4:0] o_fidx;

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic capture;
      o_we = vram_we; o_re = vram_re; o_addr = vram_addr; o_wdata = vram_wdata;
      o_fwd = reg_wr; o_fidx = reg_idx; o_fdata = reg_wdata;
   endtask

   task automatic hwrite(input logic port, input logic hi, input logic [7:0] d);
      @(negedge clk);
      host_port = port; host_hi = hi; host_wr = 1'b1; host_wdata = d;
      @(negedge clk);
      capture();
      host_wr = 1'b0;
      idle(3);
   endtask

   task automatic hread(input logic port, input logic hi, output logic [7:0] d);
      @(negedge clk);
      host_port = port; host_hi = hi; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      capture();
      host_rd = 1'b0;
      idle(3);
   endtask

   task automatic set_index(input logic [7:0] v);
      hwrite(1'b0, 1'b0, v);
      m_idx = v[4:0];
      check(!o_we && !o_re && !o_fwd, "R1 index write quiet", {o_we, o_re, o_fwd}, 0);
   endtask

   task automatic data_lo(input logic [7:0] b);
      hwrite(1'b1, 1'b0, b);
      m_lo = b;
      check(!o_we && !o_re && !o_fwd, "R3 low byte starts nothing", {o_we, o_re, o_fwd}, 0);
   endtask

   task automatic data_hi(input logic [7:0] b);
      logic [15:0] w;
      w = {b, m_lo};
      hwrite(1'b1, 1'b1, b);
      if (m_idx == 0) begin
         m_wptr = w;
         check(!o_we && !o_re && !o_fwd, "R2 wptr load quiet", {o_we, o_re, o_fwd}, 0);
      end else if (m_idx == 1) begin
         m_rptr = w;
         check(o_re && !o_we && o_addr == w, "R5 fetch on rptr load", {o_re, o_addr}, {1'b1, w});
         m_latch = peek(w);
      end else if (m_idx == 2) begin
         check(o_we && !o_re && o_addr == m_wptr && o_wdata == w, "R3 commit addr/data",
               {o_addr, o_wdata}, {m_wptr, w});
         m_wptr = m_wptr + step_of(m_sel);   // R4, R10
      end else if (m_idx >= 5 && m_idx <= 19) begin
         check(o_fwd && o_fidx == m_idx && o_fdata == w && !o_we && !o_re,
               "R9 forward", {o_fwd, o_fidx, o_fdata}, {1'b1, m_idx, w});
         if (m_idx == 5) m_sel = w[12:11];
      end else begin
         check(!o_fwd && !o_we && !o_re, "R8 reserved/out of range ignored",
               {o_fwd, o_we, o_re}, 0);
      end
   endtask

   task automatic data_rd(input logic hi);
      logic [7:0] d, e;
      hread(1'b1, hi, d);
      if (m_idx == 2) begin
         e = hi ? m_latch[15:8] : m_latch[7:0];
         check(d == e, "R5 latch byte read", d, e);
         if (hi) begin
            m_rptr = m_rptr + step_of(m_sel);
            check(o_re && o_addr == m_rptr, "R6 read advance refetch", {o_re, o_addr}, {1'b1, m_rptr});
            m_latch = peek(m_rptr);
         end else begin
            check(!o_re, "R6 low read no fetch", o_re, 0);
         end
      end else begin
         check(d == 8'h00 && !o_re, "R5 non-data read zero", {o_re, d}, 0);
      end
   endtask

   task automatic status_rd(input logic hi);
      logic [7:0] d, e;
      status_in = 16'($urandom);
      hread(1'b0, hi, d);
      e = hi ? status_in[15:8] : status_in[7:0];
      check(d == e, "R1 status byte", d, e);
   endtask

   task automatic set_step(input logic [1:0] s);
      set_index(8'd5);
      data_lo(8'h00);
      data_hi({3'b000, s, 3'b000});
   endtask

   task automatic finish_run;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h1D2C3B4A));
      idle(4);
      rst_n = 1'b1;
      idle(1);
      // R11: reset state
      check(!vram_we && !vram_re && !reg_wr, "R11 no strobes after reset",
            {vram_we, vram_re, reg_wr}, 0);
      data_lo(8'h34);
      data_hi(8'h12);                       // index 0 by reset: loads wptr
      check(m_idx == 0 && !o_we, "R11 index resets to 0", o_we, 0);
      set_index(8'd2);
      data_rd(1'b0);                        // latch still 0 from reset
      begin
         logic [7:0] d;
         hread(1'b1, 1'b0, d);
         check(d == 8'h00, "R11 latch resets to 0", d, 0);
      end
      data_lo(8'hAA); data_hi(8'h55);       // commit at 0x1234
      data_lo(8'hBB); data_hi(8'h66);       // step 1 -> 0x1235
      check(o_addr == 16'h1235, "R11 step is 1 after reset", o_addr, 16'h1235);

      // R1: high byte at the index port ignored
      hwrite(1'b0, 1'b1, 8'h05);
      data_lo(8'h01); data_hi(8'h02);       // still index 2
      check(o_we, "R1 high-byte index write ignored", o_we, 1);
      status_rd(1'b0); status_rd(1'b1);

      // R7 each step, R4 advance
      for (int s = 0; s < 4; s++) begin
         set_step(2'(s));
         set_index(8'd0); data_lo(8'h00); data_hi(8'h40);
         set_index(8'd2);
         data_lo(8'h11); data_hi(8'h22);
         data_lo(8'h33); data_hi(8'h44);
         check(o_addr == 16'h4000 + step_of(2'(s)), "R7 step decode", o_addr,
               16'h4000 + step_of(2'(s)));
      end

      // R10 wrap on both pointers at step 128
      set_step(2'd3);
      set_index(8'd0); data_lo(8'hFF); data_hi(8'hFF);
      set_index(8'd2); data_lo(8'h01); data_hi(8'h02); data_lo(8'h03); data_hi(8'h04);
      check(o_addr == 16'h007F, "R10 write pointer wrap", o_addr, 16'h007F);
      set_index(8'd1); data_lo(8'hC0); data_hi(8'hFF);
      set_index(8'd2); data_rd(1'b0); data_rd(1'b1);
      check(m_rptr == 16'h0040 && o_addr == 16'h0040, "R10 read pointer wrap", o_addr, 16'h0040);
      data_rd(1'b0); data_rd(1'b1);

      // R8 reserved and out of range keep the pointer
      foreach (m_idx[i]) ;
      for (int k = 0; k < 4; k++) begin
         logic [7:0] ri;
         ri = (k == 0) ? 8'd3 : (k == 1) ? 8'd4 : (k == 2) ? 8'd20 : 8'd31;
         set_index(ri); data_lo(8'hEE); data_hi(8'hDD);
      end
      set_index(8'd2); data_lo(8'h00); data_hi(8'h00);   // lands at model wptr

      // random phase
      for (int n = 0; n < 600; n++) begin
         int op;
         op = $urandom_range(0, 9);
         case (op)
            0: begin
               int r;
               r = $urandom_range(0, 9);
               set_index(r < 6 ? 8'(r % 3) : 8'($urandom_range(0, 23)));
            end
            1, 2: data_lo(8'($urandom));
            3, 4: data_hi(8'($urandom));
            5, 6: data_rd(1'($urandom));
            7: status_rd(1'($urandom));
            8: set_step(2'($urandom));
            default: begin
               set_index(8'd2); data_lo(8'($urandom)); data_hi(8'($urandom));
            end
         endcase
      end
      done = 1;
      finish_run();
   end
endmodule